// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block gathers write data for one eight-byte page of a 256-byte array and commits it to the array in a single timed write. A bus controller first loads a starting address, then strobes data bytes one at a time, then signals a stop. The upper five address bits pick the page. The low three bits pick the slot that the next byte lands in. That slot index advances after every byte and wraps inside the page, so a burst longer than eight bytes overwrites its own oldest slots.

A stop that follows at least one collected byte raises `busy` for a parameterised number of clock cycles, which models the write time. At the end of that window, the slots that actually received data are written into the array. Slots that received nothing leave their array bytes untouched. While `busy` is high, every bus-side strobe is ignored. A high write-protect level at the moment a byte is strobed discards that byte completely. A combinational read port exposes the array contents.

Top module: `page_commit_buf`

## Requirements
- R1: After reset `busy` is 0, no slot holds data, and every array byte reads as the erased value 0xFF.
- R2: A pulse on `addr_load` while idle sets the page to `addr_in[7:3]` and the slot index to `addr_in[2:0]`, and discards all bytes collected before it.
- R3: A pulse on `byte_valid` while idle with `wp` low stores `byte_in` in the current slot and advances only the slot index, modulo 8. The page is unchanged. The position carries over between write cycles until the next `addr_load`.
- R4: When more than eight bytes are collected, a later byte that lands in an already filled slot replaces the earlier byte.
- R5: A `stop` pulse while idle with at least one collected byte sets `busy` on the next clock edge. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R6: When `busy` falls, each filled slot has been written to the array at {page, slot}. Every other array byte is unchanged, and no slot remains filled.
- R7: A `stop` pulse while idle with no collected byte leaves `busy` low and the array unchanged.
- R8: A byte strobed while `wp` is high is dropped: it is not stored and the slot index does not advance.
- R9: While `busy` is high, `addr_load`, `byte_valid` and `stop` have no effect, and bytes strobed during that time are never committed.
- R10: `rd_data` shows the array byte at `rd_addr` in the same cycle. During a write cycle it shows the old contents.
- R11: In one idle cycle only one strobe acts, in the priority order `addr_load`, then `byte_valid`, then `stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load start address strobe |
| addr_in | input | 8 | Start address: page in [7:3], slot in [2:0] |
| byte_valid | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop | input | 1 | Stop condition strobe |
| wp | input | 1 | Write protect, high drops incoming bytes |
| busy | output | 1 | High during the timed write cycle |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The hardest state to reach is a stop, a new address and fresh bytes arriving in the middle of a write cycle. The stimulus fires all three while `busy` is high and then reads the array, both during and after the window. It then issues a further stop with no new data, to show that nothing strobed during the cycle was kept. A separate ten-byte burst fills the page past its end, so the slot that wrapped must show the newer byte. A further sequence alternates write protect between bytes, which shows that a dropped byte does not advance the slot index.

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W    = 8,
  parameter int SLOT_W    = 3,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 500000,
  parameter logic [7:0] ERASED = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop,
  input  logic              wp,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] pbuf [SLOTS];
  logic [SLOTS-1:0]  vld;
  logic [PAGE_W-1:0] page;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  cnt;

  wire done = busy && (cnt == '0);
  wire take = !busy && !addr_load && byte_valid && !wp;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      vld  <= '0;
      page <= '0;
      slot <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        vld  <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (addr_load) begin
      page <= addr_in[ADDR_W-1:SLOT_W];
      slot <= addr_in[SLOT_W-1:0];
      vld  <= '0;
    end else if (byte_valid) begin
      if (!wp) begin
        vld[slot] <= 1'b1;
        slot      <= slot + 1'b1;
      end
    end else if (stop && (vld != '0)) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(WR_CYCLES - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[slot] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (done) begin
      for (int i = 0; i < SLOTS; i++)
        if (vld[i]) mem[{page, SLOT_W'(i)}] <= pbuf[i];
    end
  end
endmodule

// File: rtl/page_commit_buf_chk.sv
module page_commit_buf_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int SLOTS     = 8,
  parameter int CNT_W     = 19,
  parameter int WR_CYCLES = 500000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              stop,
  input logic              wp,
  input logic              byte_valid,
  input logic              addr_load,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [SLOTS-1:0]  vld,
  input logic [CNT_W-1:0]  cnt
);
  int blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> blen == WR_CYCLES); // R5
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop && !addr_load && !byte_valid && vld == '0) |=> !busy); // R7
  AST_WP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wp && byte_valid && !addr_load) |=> $stable(vld)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && $stable(vld))); // R9
  AST_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> vld == '0); // R6
  AST_IDLE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!$stable(rd_addr) || $stable(rd_data))); // R10
endmodule

bind page_commit_buf page_commit_buf_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .stop(stop), .wp(wp),
  .byte_valid(byte_valid), .addr_load(addr_load), .rd_addr(rd_addr),
  .rd_data(rd_data), .vld(vld), .cnt(cnt)
);

// File: tb/sim_page_commit_buf.sv
`timescale 1ns/1ps
module sim_page_commit_buf;
  localparam int WRC = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_load = 0, byte_valid = 0, stop = 0, wp = 0;
  logic [7:0] addr_in = 0, byte_in = 0, rd_addr = 0;
  logic busy;
  logic [7:0] rd_data;
  int total = 0, bad = 0;

  page_commit_buf #(.WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_in(byte_in), .stop(stop), .wp(wp),
    .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data));

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic load(logic [7:0] a);
    @(negedge clk); addr_load = 1; addr_in = a;
    @(negedge clk); addr_load = 0;
  endtask

  task automatic put(logic [7:0] b);
    @(negedge clk); byte_valid = 1; byte_in = b;
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    rd(8'h00, 8'hFF, "R1 mem 00");
    rd(8'hFF, 8'hFF, "R1 mem FF");
  endtask

  task automatic t_single();
    int n;
    load(8'h13); put(8'hA5); pulse_stop();
    check("R5 busy rises", busy, 1);
    rd(8'h13, 8'hFF, "R10 old data during busy");
    wait_busy(n);
    check("R5 busy length", n, WRC);
    rd(8'h13, 8'hA5, "R6 byte written");
    rd(8'h12, 8'hFF, "R6 neighbour low");
    rd(8'h14, 8'hFF, "R6 neighbour high");
  endtask

  task automatic t_wrap_partial();
    int n;
    load(8'h2E); put(8'h01); put(8'h02); put(8'h03);
    pulse_stop(); wait_busy(n);
    check("R5 busy length 2", n, WRC);
    rd(8'h2E, 8'h01, "R3 slot6");
    rd(8'h2F, 8'h02, "R3 slot7");
    rd(8'h28, 8'h03, "R3 wrap to slot0");
    rd(8'h2A, 8'hFF, "R6 unfilled slot");
    rd(8'h30, 8'hFF, "R3 next page untouched");
  endtask

  task automatic t_overflow();
    int n;
    load(8'h40);
    for (int i = 0; i < 10; i++) put(8'h80 + 8'(i));
    pulse_stop(); wait_busy(n);
    rd(8'h40, 8'h88, "R4 slot0 overwritten");
    rd(8'h41, 8'h89, "R4 slot1 overwritten");
    rd(8'h42, 8'h82, "R4 slot2 kept");
    rd(8'h47, 8'h87, "R4 slot7 kept");
  endtask

  task automatic t_empty_stop();
    load(8'h50); pulse_stop();
    check("R7 no busy", busy, 0);
    repeat (3) @(negedge clk);
    check("R7 still idle", busy, 0);
    rd(8'h50, 8'hFF, "R7 mem unchanged");
  endtask

  task automatic t_wp();
    int n;
    wp = 1; load(8'h60); put(8'h11); put(8'h22); pulse_stop();
    check("R8 protected no busy", busy, 0);
    rd(8'h60, 8'hFF, "R8 protected mem");
    load(8'h68);
    wp = 0; put(8'hC1);
    wp = 1; put(8'hC2);
    wp = 0; put(8'hC3);
    pulse_stop(); wait_busy(n);
    rd(8'h68, 8'hC1, "R8 first byte");
    rd(8'h69, 8'hC3, "R8 slot not advanced");
    rd(8'h6A, 8'hFF, "R8 no extra slot");
  endtask

  task automatic t_busy_ignore();
    int n;
    load(8'h70); put(8'h5A); pulse_stop();
    load(8'h80); put(8'h22); pulse_stop();
    check("R9 still busy", busy, 1);
    rd(8'h70, 8'hFF, "R10 old during busy");
    wait_busy(n);
    check("R9 length unaffected", n, WRC - 6);
    rd(8'h70, 8'h5A, "R9 commit");
    rd(8'h80, 8'hFF, "R9 ignored byte");
    pulse_stop();
    check("R9 busy-time byte not kept", busy, 0);
    put(8'h33); pulse_stop(); wait_busy(n);
    rd(8'h71, 8'h33, "R3 position carried over");
  endtask

  task automatic t_reload();
    int n;
    load(8'h90); put(8'h44); load(8'h98); put(8'h55);
    pulse_stop(); wait_busy(n);
    rd(8'h90, 8'hFF, "R2 discarded byte");
    rd(8'h98, 8'h55, "R2 new start");
  endtask

  task automatic t_priority();
    int n;
    @(negedge clk); addr_load = 1; addr_in = 8'hA3; byte_valid = 1; byte_in = 8'hEE; stop = 1;
    @(negedge clk); addr_load = 0; byte_valid = 0; stop = 0;
    check("R11 load wins", busy, 0);
    put(8'h77);
    @(negedge clk); byte_valid = 1; byte_in = 8'h78; stop = 1;
    @(negedge clk); byte_valid = 0; stop = 0;
    check("R11 byte beats stop", busy, 0);
    pulse_stop(); wait_busy(n);
    rd(8'hA3, 8'h77, "R11 first byte");
    rd(8'hA4, 8'h78, "R11 second byte");
  endtask

  logic fin = 0;
  initial begin
    #(2_000_000);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_wrap_partial();
    t_overflow();
    t_empty_stop();
    t_wp();
    t_busy_ignore();
    t_reload();
    t_priority();
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule